// File: doc/BRIEF.md
# CEC Frame Transmitter

This block sends messages on the single-wire, open-drain consumer-electronics control bus, one byte at a time. Software-style control comes through a one-byte holding register, a start strobe, an end strobe and an enable. Once started, the block waits for the line to stay free for a set number of nominal bit periods. It then drives a start bit and sends every byte as eight data bits (most significant first), an end-of-message bit and an acknowledge slot.

The bus is never driven high. The block only pulls the line low through `cec_drive_low` and reads the resolved level back on `cec_in`. The read-back is used three ways: to restart the free-time count, to sample the acknowledge slot, and to spot another initiator pulling the line low while this block has released it. Each message ends with exactly one single-cycle outcome pulse: done, no acknowledge, bit error, arbitration lost or underrun. A request pulse marks each byte taken from the holding register.

All durations are counted in ticks. A tick is `TICK_DIV` clock cycles. The default tick counts follow the nominal timings of the bus at a 32 kHz-class tick.

Top module: `cec_tx_engine`

## Requirements
- R1: After reset, `cec_drive_low`, `busy` and every flag output are 0.
- R2: After a start request, the start bit begins only once the line has been sensed released for N consecutive bit periods (BIT_PER ticks each). N is 5 when `sft_sel` is 0 and equals `sft_sel` otherwise. Any low level on the line restarts the count. The start bit begins no earlier than N·BIT_PER ticks and no later than 4 clock cycles after that.
- R3: A start bit pulls the line low for START_LOW ticks within a START_PER-tick period.
- R4: Each bit slot lasts BIT_PER ticks. A 0 is low for ZERO_LOW ticks and a 1 for ONE_LOW ticks. A byte is sent as its 8 data bits, most significant first, then an end-of-message bit, then an acknowledge slot that this block sends as a 1.
- R5: If no byte has been written when the free time ends, `underrun` pulses and the line is never driven.
- R6: `byte_req` pulses once each time a byte is taken from the holding register. That byte's end-of-message bit is 1 exactly when the `eom` strobe came after the previous byte was taken. For a one-byte message, this means `eom` must be given before `som`.
- R7: If a byte without end-of-message has been sent and acknowledged, and no new byte has been written by the end of its acknowledge slot, `underrun` pulses and the line stays released.
- R8: `tx_done` pulses only after the byte carrying end-of-message has been acknowledged.
- R9: The line is sampled in the acknowledge slot. The destination is the low nibble of the first byte. For a direct destination, a high sample is a missing acknowledge. For destination 4'hF (broadcast), a low sample is a missing acknowledge. On a missing acknowledge, `nack` pulses and the message stops.
- R10: If the line is sensed low at the sample point of a 1 bit among the first four bits of the first byte (the initiator field), `arb_lost` pulses and the block stops driving at once.
- R11: The same low sample on any other 1 bit, including an end-of-message 1, pulses `tx_err` and stops the message.
- R12: While `enable` is 0, the block stays idle, the line is released, and `som` is ignored. Dropping `enable` during a message releases the line on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable |
| sft_sel | input | 3 | Signal-free time in bit periods; 0 selects the default of 5 |
| tx_data | input | 8 | Byte to load into the holding register |
| tx_wr | input | 1 | Write strobe for `tx_data` |
| som | input | 1 | Start-of-message strobe |
| eom | input | 1 | Marks the next byte taken as the last one |
| cec_in | input | 1 | Resolved bus level |
| cec_drive_low | output | 1 | Pull the bus low when 1 |
| busy | output | 1 | A message is waiting or in progress |
| byte_req | output | 1 | Pulse: a byte was taken, load the next |
| underrun | output | 1 | Pulse: no byte ready when needed |
| tx_done | output | 1 | Pulse: last byte acknowledged |
| nack | output | 1 | Pulse: acknowledge missing |
| tx_err | output | 1 | Pulse: line low while released |
| arb_lost | output | 1 | Pulse: lost the initiator field to another device |

## Verification
The hardest cases need a second device on the wire that reacts to this block's own edges. That device must acknowledge, stay silent, or pull a chosen bit low at the right moment. The bench therefore models the wired-AND bus together with a follower. The follower counts falling edges from the start bit and stretches the low level of a chosen slot. With it, the bench can acknowledge every tenth slot, override one initiator bit to force arbitration loss, or override one destination bit to force a bit error. It also holds the line low during the free-time wait to show that the count restarts.

// File: rtl/cec_tx_engine.sv
module cec_tx_engine #(
  parameter int TICK_DIV    = 4,
  parameter int START_LOW   = 120,
  parameter int START_PER   = 147,
  parameter int ZERO_LOW    = 49,
  parameter int ONE_LOW     = 20,
  parameter int BIT_PER     = 79,
  parameter int SAMPLE_AT   = 34,
  parameter int SFT_DEFAULT = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic [2:0] sft_sel,
  input  logic [7:0] tx_data,
  input  logic       tx_wr,
  input  logic       som,
  input  logic       eom,
  input  logic       cec_in,
  output logic       cec_drive_low,
  output logic       busy,
  output logic       byte_req,
  output logic       underrun,
  output logic       tx_done,
  output logic       nack,
  output logic       tx_err,
  output logic       arb_lost
);
  localparam int SFT_MAX = 7 * BIT_PER;
  localparam int CW = $clog2((SFT_MAX > START_PER ? SFT_MAX : START_PER) + 1) + 1;
  localparam int DW = $clog2(TICK_DIV + 1);

  typedef enum logic [1:0] {IDLE, WAIT, START, BITS} st_t;
  st_t st;

  logic [DW-1:0] pre;
  logic          tick;
  logic [CW-1:0] cnt, sft_need;
  logic [3:0]    slot;
  logic [7:0]    shreg, hold;
  logic          hold_full, som_q, eom_q, eom_bit, first, bcast;
  logic [1:0]    sync;
  logic          line_s, cur;
  logic [2:0]    sft_n;

  assign tick     = (pre == DW'(TICK_DIV - 1));
  assign line_s   = sync[1];
  assign sft_n    = (sft_sel == 3'd0) ? 3'(SFT_DEFAULT) : sft_sel;
  assign sft_need = CW'(sft_n) * CW'(BIT_PER);
  assign cur      = (slot < 4'd8) ? shreg[7] : (slot == 4'd8) ? eom_bit : 1'b1;
  assign busy     = (st != IDLE);
  assign cec_drive_low = (st == START && cnt < CW'(START_LOW)) ||
                         (st == BITS && cnt < (cur ? CW'(ONE_LOW) : CW'(ZERO_LOW)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre <= '0;
      sync <= 2'b11;
    end else begin
      pre <= tick ? '0 : pre + 1'b1;
      sync <= {sync[0], cec_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; cnt <= '0; slot <= '0; shreg <= '0; hold <= '0;
      hold_full <= 1'b0; som_q <= 1'b0; eom_q <= 1'b0; eom_bit <= 1'b0;
      first <= 1'b0; bcast <= 1'b0;
      byte_req <= 1'b0; underrun <= 1'b0; tx_done <= 1'b0;
      nack <= 1'b0; tx_err <= 1'b0; arb_lost <= 1'b0;
    end else begin
      byte_req <= 1'b0; underrun <= 1'b0; tx_done <= 1'b0;
      nack <= 1'b0; tx_err <= 1'b0; arb_lost <= 1'b0;
      if (eom) eom_q <= 1'b1;
      if (som && enable && st == IDLE) som_q <= 1'b1;
      if (!enable) begin
        st <= IDLE; som_q <= 1'b0; eom_q <= 1'b0; cnt <= '0;
      end else begin
        case (st)
          IDLE: if (som_q) begin
            st <= WAIT; cnt <= '0; som_q <= 1'b0;
          end
          WAIT: begin
            if (!line_s) cnt <= '0;
            else if (tick) begin
              if (cnt == sft_need - 1'b1) begin
                cnt <= '0;
                if (hold_full) begin
                  st <= START; shreg <= hold; hold_full <= 1'b0;
                  eom_bit <= eom_q; eom_q <= 1'b0; byte_req <= 1'b1;
                  first <= 1'b1; bcast <= (hold[3:0] == 4'hF);
                end else begin
                  st <= IDLE; underrun <= 1'b1;
                end
              end else cnt <= cnt + 1'b1;
            end
          end
          START: if (tick) begin
            if (cnt == CW'(START_PER - 1)) begin
              st <= BITS; cnt <= '0; slot <= '0;
            end else cnt <= cnt + 1'b1;
          end
          BITS: if (tick) begin
            cnt <= cnt + 1'b1;
            if (cnt == CW'(SAMPLE_AT - 1)) begin
              if (slot == 4'd9) begin
                if (bcast ? !line_s : line_s) begin
                  st <= IDLE; nack <= 1'b1;
                end
              end else if (cur && !line_s) begin
                st <= IDLE;
                if (first && slot < 4'd4) arb_lost <= 1'b1;
                else tx_err <= 1'b1;
              end
            end else if (cnt == CW'(BIT_PER - 1)) begin
              cnt <= '0;
              if (slot == 4'd9) begin
                if (eom_bit) begin
                  st <= IDLE; tx_done <= 1'b1;
                end else if (hold_full) begin
                  shreg <= hold; hold_full <= 1'b0; eom_bit <= eom_q;
                  eom_q <= 1'b0; byte_req <= 1'b1; first <= 1'b0; slot <= '0;
                end else begin
                  st <= IDLE; underrun <= 1'b1;
                end
              end else begin
                slot <= slot + 1'b1;
                if (slot < 4'd8) shreg <= {shreg[6:0], 1'b0};
              end
            end
          end
          default: st <= IDLE;
        endcase
      end
      if (tx_wr) begin
        hold <= tx_data; hold_full <= 1'b1;
      end
    end
  end
endmodule

module cec_tx_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic cec_drive_low,
  input logic busy,
  input logic byte_req,
  input logic underrun,
  input logic tx_done,
  input logic nack,
  input logic tx_err,
  input logic arb_lost
);
  a_r1_single_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tx_done, nack, tx_err, arb_lost, underrun}));
  a_r4_drive_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    cec_drive_low |-> busy);
  a_r6_req_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    byte_req |-> busy);
  a_r8_done_ends_message: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> !busy);
  a_r10_arb_release: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost |=> !cec_drive_low);
  a_r12_disable_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!busy && !cec_drive_low));
endmodule

bind cec_tx_engine cec_tx_engine_chk chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .cec_drive_low(cec_drive_low),
  .busy(busy), .byte_req(byte_req), .underrun(underrun), .tx_done(tx_done),
  .nack(nack), .tx_err(tx_err), .arb_lost(arb_lost)
);

// File: tb/cec_tx_engine_test.sv
`timescale 1ns/1ps
module cec_tx_engine_test;
  localparam int ZL = 49;
  localparam int BP = 79;

  logic clk = 0, rst_n = 0, enable = 1, tx_wr = 0, som = 0, eom = 0;
  logic [2:0] sft_sel = 0;
  logic [7:0] tx_data = 0;
  logic drv_uut, busy, byte_req, underrun, tx_done, nack, tx_err, arb_lost;
  logic force_low = 0, ack_on = 0, clr = 0;
  int   ovr_edge = -1;
  int   other_cnt = 0, edges = 0, lowcnt = 0, nlow = 0, nreq = 0;
  int   cyc = 0, first_drive = -1;
  logic line_d = 1, s_done = 0, s_nack = 0, s_err = 0, s_arb = 0, s_und = 0, drive_seen = 0;
  int   lows [64];
  int   n_chk = 0, n_fail = 0;
  wire  line = ~(drv_uut | (other_cnt > 0) | force_low);

  always #4 clk = ~clk;

  cec_tx_engine #(.TICK_DIV(1)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .sft_sel(sft_sel),
    .tx_data(tx_data), .tx_wr(tx_wr), .som(som), .eom(eom), .cec_in(line),
    .cec_drive_low(drv_uut), .busy(busy), .byte_req(byte_req),
    .underrun(underrun), .tx_done(tx_done), .nack(nack), .tx_err(tx_err),
    .arb_lost(arb_lost));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    line_d <= line;
    if (other_cnt > 0) other_cnt <= other_cnt - 1;
    if (clr) begin
      edges <= 0; nlow <= 0; nreq <= 0; first_drive <= -1; lowcnt <= 0;
      s_done <= 0; s_nack <= 0; s_err <= 0; s_arb <= 0; s_und <= 0; drive_seen <= 0;
    end else begin
      if (line_d && !line) begin
        edges <= edges + 1;
        lowcnt <= 1;
        if (edges > 0 && ((ack_on && edges % 10 == 0) || edges == ovr_edge)) other_cnt <= ZL;
      end else if (!line) lowcnt <= lowcnt + 1;
      if (!line_d && line && nlow < 64) begin
        lows[nlow] <= lowcnt; nlow <= nlow + 1;
      end
      if (drv_uut && first_drive < 0) first_drive <= cyc;
      if (drv_uut) drive_seen <= 1;
      if (byte_req) nreq <= nreq + 1;
      if (tx_done) s_done <= 1;
      if (nack) s_nack <= 1;
      if (tx_err) s_err <= 1;
      if (arb_lost) s_arb <= 1;
      if (underrun) s_und <= 1;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic restart();
    @(negedge clk);
    while (other_cnt > 0) @(negedge clk);
    rst_n = 0; enable = 1; ack_on = 0; ovr_edge = -1; force_low = 0; sft_sel = 0;
    clr = 1;
    cycles(3);
    rst_n = 1; clr = 0;
    cycles(2);
  endtask

  task automatic wr(input logic [7:0] b);
    tx_data = b; tx_wr = 1; @(negedge clk); tx_wr = 0;
  endtask

  task automatic pulse_eom();
    eom = 1; @(negedge clk); eom = 0;
  endtask

  task automatic pulse_som(output int t);
    t = cyc; som = 1; @(negedge clk); som = 0;
  endtask

  task automatic wait_end(input int maxc);
    for (int i = 0; i < maxc; i++) begin
      if (s_done | s_nack | s_err | s_arb | s_und) break;
      @(negedge clk);
    end
  endtask

  function automatic int get_byte(input int b);
    int v = 0;
    for (int i = 0; i < 8; i++) v = (v << 1) | ((lows[1 + b*10 + i] < 35) ? 1 : 0);
    return v;
  endfunction

  function automatic int get_eom(input int b);
    return (lows[1 + b*10 + 8] < 35) ? 1 : 0;
  endfunction

  task automatic t_reset();
    restart();
    check(!drv_uut && !busy, "R1 line and busy after reset", int'(drv_uut | busy), 0);
    check({byte_req, underrun, tx_done, nack, tx_err, arb_lost} == 6'b0,
          "R1 flags after reset", int'({byte_req, underrun, tx_done, nack, tx_err, arb_lost}), 0);
  endtask

  task automatic t_one_byte();
    int t0;
    restart();
    ack_on = 1;
    wr(8'h40); pulse_eom(); pulse_som(t0);
    wait_end(3000); cycles(5);
    check(first_drive - t0 >= 5*BP && first_drive - t0 <= 5*BP + 4,
          "R2 default free time", first_drive - t0, 5*BP);
    check(lows[0] >= 118 && lows[0] <= 122, "R3 start low width", lows[0], 120);
    check(get_byte(0) == 8'h40, "R4 header bits msb first", get_byte(0), 8'h40);
    check(get_eom(0) == 1, "R6 eom bit on single byte", get_eom(0), 1);
    check(nreq == 1, "R6 one byte request", nreq, 1);
    check(s_done && !s_nack, "R8 done after ack", int'(s_done), 1);
  endtask

  task automatic t_multi();
    int t0;
    restart();
    ack_on = 1; sft_sel = 3;
    wr(8'h40); pulse_som(t0);
    while (nreq < 1) @(negedge clk);
    wr(8'h12);
    while (nreq < 2) @(negedge clk);
    wr(8'hA5); pulse_eom();
    wait_end(5000); cycles(5);
    check(first_drive - t0 >= 3*BP && first_drive - t0 <= 3*BP + 4,
          "R2 programmed free time", first_drive - t0, 3*BP);
    check(get_byte(1) == 8'h12 && get_byte(2) == 8'hA5, "R4 payload bytes",
          get_byte(1) * 256 + get_byte(2), 16'h12A5);
    check(get_eom(0) == 0 && get_eom(1) == 0 && get_eom(2) == 1, "R6 eom only on last",
          get_eom(0)*4 + get_eom(1)*2 + get_eom(2), 1);
    check(nreq == 3 && s_done, "R8 three-byte done", nreq, 3);
  endtask

  task automatic t_underrun_start();
    int t0;
    restart();
    pulse_som(t0);
    wait_end(1500); cycles(5);
    check(s_und && !drive_seen, "R5 underrun with empty register", int'(s_und), 1);
  endtask

  task automatic t_underrun_mid();
    int t0;
    restart();
    ack_on = 1;
    wr(8'h40); pulse_som(t0);
    wait_end(3000); cycles(300);
    check(s_und && !s_done, "R7 underrun after first byte", int'(s_und), 1);
    check(nlow == 11, "R7 line released after underrun", nlow, 11);
  endtask

  task automatic t_nack();
    int t0;
    restart();
    wr(8'h40); pulse_eom(); pulse_som(t0);
    wait_end(3000);
    check(s_nack && !s_done, "R9 missing ack direct", int'(s_nack), 1);
  endtask

  task automatic t_bcast();
    int t0;
    restart();
    wr(8'h4F); pulse_eom(); pulse_som(t0);
    wait_end(3000);
    check(s_done && !s_nack, "R9 broadcast silent is ok", int'(s_done), 1);
    restart();
    ack_on = 1;
    wr(8'h4F); pulse_eom(); pulse_som(t0);
    wait_end(3000);
    check(s_nack && !s_done, "R9 broadcast low is refusal", int'(s_nack), 1);
  endtask

  task automatic t_arb();
    int t0;
    restart();
    ovr_edge = 2;
    wr(8'h40); pulse_eom(); pulse_som(t0);
    wait_end(3000);
    drive_seen = 0;
    cycles(1); clr = 0;
    check(s_arb && !s_err, "R10 arbitration lost on initiator bit", int'(s_arb), 1);
    begin
      bit drove = 0;
      for (int i = 0; i < 400; i++) begin
        if (drv_uut) drove = 1;
        @(negedge clk);
      end
      check(!drove && !busy, "R10 stops driving", int'(drove), 0);
    end
  endtask

  task automatic t_txerr();
    int t0;
    restart();
    ovr_edge = 6;
    wr(8'h45); pulse_eom(); pulse_som(t0);
    wait_end(3000);
    check(s_err && !s_arb, "R11 bit error outside initiator field", int'(s_err), 1);
  endtask

  task automatic t_sft_hold();
    int t0;
    restart();
    sft_sel = 3;
    wr(8'h40); pulse_eom(); pulse_som(t0);
    cycles(150); force_low = 1; cycles(100); force_low = 0;
    while (first_drive < 0 && cyc - t0 < 2000) @(negedge clk);
    check(first_drive - t0 >= 250 + 3*BP && first_drive - t0 <= 250 + 3*BP + 8,
          "R2 low line restarts free time", first_drive - t0, 250 + 3*BP);
  endtask

  task automatic t_disable();
    int t0;
    bit drove;
    restart();
    enable = 0;
    wr(8'h40); pulse_eom(); pulse_som(t0);
    cycles(800);
    enable = 1;
    cycles(800);
    check(!drive_seen && !busy, "R12 som ignored while disabled", int'(drive_seen), 0);
    pulse_som(t0);
    while (!drv_uut && cyc - t0 < 1000) @(negedge clk);
    cycles(200);
    enable = 0;
    @(negedge clk);
    drove = 0;
    for (int i = 0; i < 300; i++) begin
      if (drv_uut || busy) drove = 1;
      @(negedge clk);
    end
    check(!drove, "R12 disable releases the line", int'(drove), 0);
  endtask

  initial begin
    t_reset();
    t_one_byte();
    t_multi();
    t_underrun_start();
    t_underrun_mid();
    t_nack();
    t_bcast();
    t_arb();
    t_txerr();
    t_sft_hold();
    t_disable();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(8 * 190000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule